// File: doc/BRIEF.md
# ADC sequence status flag controller

This block follows an analog-to-digital conversion sequence and reports its progress to software. It keeps a sequence-done flag, a conversion pointer and one conversion-done flag per result slot. A register bus reaches two status bytes and a 16-bit test word, and software starts new sequences through the same bus. The converter core pulses `conv_done` once for each finished conversion. The flags set on those pulses and clear again according to one of two policies.

Under the fast policy (`fast_clr` = 1), a read of a result slot alone clears that slot's flag. Under the normal policy, a read of status byte 1 must come before the result read. The status read arms only the flags that were set at that moment.

The register bus has no back-pressure. Every access completes in the cycle it is presented, and `reg_rdata` is combinational from the address while `reg_rd` is high. This block returns zero for result-slot reads, because the result data is muxed in elsewhere. Outside special mode the status bytes are read-only and the test word is hidden.

Top module: `adc_seq_status`

## Requirements
- R1: After reset, the pointer, every flag, the sequence-done flag, the active state and the test word are all zero.
- R2: Address 0x2 reads {seq_flag, 4'b0000, pointer[2:0]} and address 0x3 reads the eight done flags, with bit i for slot i. Address 0x0 is the start register, 0x4 and 0x5 are the high and low test bytes, and 0x8+i is result slot i. All other reads return zero.
- R3: Each accepted conversion advances the pointer by one. After the last slot the pointer wraps to 0. The sequence length is 4 when `seq_len8` = 0 and 8 when it is 1.
- R4: With `scan_cont` = 0 the block goes idle after the last conversion and ignores `conv_done` while idle. With `scan_cont` = 1 it keeps converting with no further writes.
- R5: The sequence-done flag sets when the last conversion of a single sequence completes. In continuous mode it sets only at the end of the first pass after a start.
- R6: An accepted conversion sets the done flag of the slot the pointer held at that time.
- R7: Any write to address 0x0 clears the pointer, all done flags, the arming state and the sequence-done flag, and makes the block active. A `conv_done` in that same cycle is ignored.
- R8: With `fast_clr` = 1, reading result slot i clears done flag i, and reading slot 0 also clears the sequence-done flag.
- R9: With `fast_clr` = 0, reading slot i clears flag i only if a read of address 0x3 came first while flag i was set. Without that read, the flag stays set.
- R10: If a flag is set and cleared in the same cycle, it ends up set.
- R11: In special mode, writes to 0x2 (bit 7) and 0x3 load the sequence-done flag and the done flags. Outside special mode those writes have no effect.
- R12: The test word is read and written only in special mode. Outside special mode its reads return zero and its writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| conv_done | input | 1 | One-cycle pulse per finished conversion |
| scan_cont | input | 1 | 1 = continuous scan, 0 = single sequence |
| seq_len8 | input | 1 | 1 = eight conversions, 0 = four |
| fast_clr | input | 1 | 1 = result read alone clears flags |
| special_mode | input | 1 | Enables status writes and test access |
| conv_ptr | output | 3 | Slot written next, which is the channel now converting |
| seq_active | output | 1 | Sequence in progress |
| seq_flag | output | 1 | Sequence-done flag |
| cc_flags | output | 8 | Per-slot done flags |
| test_word | output | 16 | Test register contents |

## Verification
A conversion that sets a slot's flag and a result read that clears the same flag can fall in the same cycle. The bench provokes this under the fast policy. It pulses `conv_done` while the pointer sits on slot 1 and, on the same edge, reads result slot 1. It judges the outcome by observing `cc_flags[1]` high afterwards. A bound property also checks, for every accepted conversion, that the slot the pointer held is set on the next cycle, whatever bus access happened alongside.

// File: rtl/adc_stat_pkg.sv
package adc_stat_pkg;
  localparam int OFS_START = 0;
  localparam int OFS_STAT0 = 2;
  localparam int OFS_STAT1 = 3;
  localparam int OFS_TSTH  = 4;
  localparam int OFS_TSTL  = 5;

  typedef struct packed {
    logic start_wr;
    logic stat0_wr;
    logic stat1_wr;
    logic stat1_rd;
    logic tsth_wr;
    logic tstl_wr;
    logic res_rd;
  } bus_evt_t;
endpackage

// File: rtl/adc_bus_decode.sv
module adc_bus_decode
  import adc_stat_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int PTR_W  = 3
) (
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              special_mode,
  output bus_evt_t          evt,
  output logic [PTR_W-1:0]  res_idx
);
  logic res_space;
  assign res_space = reg_addr[ADDR_W-1];
  assign res_idx   = reg_addr[PTR_W-1:0];

  always_comb begin
    evt          = '0;
    evt.start_wr = reg_wr && (reg_addr == ADDR_W'(OFS_START));
    evt.stat0_wr = reg_wr && special_mode && (reg_addr == ADDR_W'(OFS_STAT0));
    evt.stat1_wr = reg_wr && special_mode && (reg_addr == ADDR_W'(OFS_STAT1));
    evt.stat1_rd = reg_rd && (reg_addr == ADDR_W'(OFS_STAT1));
    evt.tsth_wr  = reg_wr && special_mode && (reg_addr == ADDR_W'(OFS_TSTH));
    evt.tstl_wr  = reg_wr && special_mode && (reg_addr == ADDR_W'(OFS_TSTL));
    evt.res_rd   = reg_rd && res_space;
  end
endmodule

// File: rtl/adc_seq_tracker.sv
module adc_seq_tracker #(
  parameter int NUM_RES = 8,
  parameter int PTR_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             conv_done,
  input  logic             scan_cont,
  input  logic             seq_len8,
  input  logic             fast_clr,
  input  logic             res_rd,
  input  logic [PTR_W-1:0] res_idx,
  input  logic             seq_wr,
  input  logic             seq_wbit,
  output logic [PTR_W-1:0] ptr,
  output logic             active,
  output logic             seq_flag,
  output logic             conv_fire
);
  localparam logic [PTR_W-1:0] LAST_LONG  = PTR_W'(NUM_RES - 1);
  localparam logic [PTR_W-1:0] LAST_SHORT = PTR_W'(NUM_RES / 2 - 1);

  logic first_done;
  logic at_last;

  assign conv_fire = active && conv_done && !start;
  assign at_last   = (ptr == (seq_len8 ? LAST_LONG : LAST_SHORT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr        <= '0;
      active     <= 1'b0;
      seq_flag   <= 1'b0;
      first_done <= 1'b0;
    end else if (start) begin
      ptr        <= '0;
      active     <= 1'b1;
      seq_flag   <= 1'b0;
      first_done <= 1'b0;
    end else begin
      if (seq_wr)
        seq_flag <= seq_wbit;
      else if (fast_clr && res_rd && (res_idx == '0))
        seq_flag <= 1'b0;
      if (conv_fire) begin
        if (at_last) begin
          ptr <= '0;
          if (!scan_cont) active <= 1'b0;
          if (!first_done) begin
            seq_flag   <= 1'b1;
            first_done <= 1'b1;
          end
        end else begin
          ptr <= ptr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_flag_bank.sv
module adc_flag_bank #(
  parameter int NUM_RES = 8,
  parameter int PTR_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               conv_fire,
  input  logic [PTR_W-1:0]   conv_idx,
  input  logic               res_rd,
  input  logic [PTR_W-1:0]   res_idx,
  input  logic               stat_rd,
  input  logic               stat_wr,
  input  logic [NUM_RES-1:0] wvalue,
  input  logic               fast_clr,
  output logic [NUM_RES-1:0] flags
);
  logic [NUM_RES-1:0] armed;

  for (genvar gi = 0; gi < NUM_RES; gi++) begin : g_slot
    logic set_i, hit_i, clr_i;
    assign set_i = conv_fire && (conv_idx == PTR_W'(gi));
    assign hit_i = res_rd && (res_idx == PTR_W'(gi));
    assign clr_i = hit_i && (fast_clr || armed[gi]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags[gi] <= 1'b0;
        armed[gi] <= 1'b0;
      end else if (start) begin
        flags[gi] <= 1'b0;
        armed[gi] <= 1'b0;
      end else begin
        if (set_i)        flags[gi] <= 1'b1;
        else if (stat_wr) flags[gi] <= wvalue[gi];
        else if (clr_i)   flags[gi] <= 1'b0;

        if (stat_rd)      armed[gi] <= flags[gi];
        else if (hit_i)   armed[gi] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_test_reg.sv
module adc_test_reg #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hi_wr,
  input  logic                lo_wr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [2*DATA_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else begin
      if (hi_wr) word[2*DATA_W-1:DATA_W] <= wdata;
      if (lo_wr) word[DATA_W-1:0]        <= wdata;
    end
  end
endmodule

// File: rtl/adc_seq_status.sv
module adc_seq_status
  import adc_stat_pkg::*;
#(
  parameter int NUM_RES = 8,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int PTR_W   = $clog2(NUM_RES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                conv_done,
  input  logic                scan_cont,
  input  logic                seq_len8,
  input  logic                fast_clr,
  input  logic                special_mode,
  output logic [PTR_W-1:0]    conv_ptr,
  output logic                seq_active,
  output logic                seq_flag,
  output logic [NUM_RES-1:0]  cc_flags,
  output logic [2*DATA_W-1:0] test_word
);
  bus_evt_t         evt;
  logic [PTR_W-1:0] res_idx;
  logic             conv_fire;

  adc_bus_decode #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_dec (
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .special_mode(special_mode), .evt(evt), .res_idx(res_idx)
  );

  adc_seq_tracker #(.NUM_RES(NUM_RES), .PTR_W(PTR_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .start(evt.start_wr), .conv_done(conv_done),
    .scan_cont(scan_cont), .seq_len8(seq_len8), .fast_clr(fast_clr),
    .res_rd(evt.res_rd), .res_idx(res_idx), .seq_wr(evt.stat0_wr),
    .seq_wbit(reg_wdata[DATA_W-1]), .ptr(conv_ptr), .active(seq_active),
    .seq_flag(seq_flag), .conv_fire(conv_fire)
  );

  adc_flag_bank #(.NUM_RES(NUM_RES), .PTR_W(PTR_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .start(evt.start_wr), .conv_fire(conv_fire),
    .conv_idx(conv_ptr), .res_rd(evt.res_rd), .res_idx(res_idx),
    .stat_rd(evt.stat1_rd), .stat_wr(evt.stat1_wr),
    .wvalue(reg_wdata[NUM_RES-1:0]), .fast_clr(fast_clr), .flags(cc_flags)
  );

  adc_test_reg #(.DATA_W(DATA_W)) u_tst (
    .clk(clk), .rst_n(rst_n), .hi_wr(evt.tsth_wr), .lo_wr(evt.tstl_wr),
    .wdata(reg_wdata), .word(test_word)
  );

  logic [DATA_W-1:0] stat0_byte, stat1_byte;
  always_comb begin
    stat0_byte               = '0;
    stat0_byte[DATA_W-1]     = seq_flag;
    stat0_byte[PTR_W-1:0]    = conv_ptr;
    stat1_byte               = '0;
    stat1_byte[NUM_RES-1:0]  = cc_flags;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (reg_addr == ADDR_W'(OFS_STAT0))
        reg_rdata = stat0_byte;
      else if (reg_addr == ADDR_W'(OFS_STAT1))
        reg_rdata = stat1_byte;
      else if (special_mode && reg_addr == ADDR_W'(OFS_TSTH))
        reg_rdata = test_word[2*DATA_W-1:DATA_W];
      else if (special_mode && reg_addr == ADDR_W'(OFS_TSTL))
        reg_rdata = test_word[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/adc_seq_status_chk.sv
module adc_seq_status_chk
  import adc_stat_pkg::*;
#(
  parameter int NUM_RES = 8,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int PTR_W   = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic                reg_wr,
  input logic                reg_rd,
  input logic [DATA_W-1:0]   reg_rdata,
  input logic                conv_done,
  input logic                seq_len8,
  input logic                fast_clr,
  input logic                special_mode,
  input logic [PTR_W-1:0]    conv_ptr,
  input logic                seq_active,
  input logic                seq_flag,
  input logic [NUM_RES-1:0]  cc_flags
);
  logic               start_w, accepted;
  logic [NUM_RES-1:0] ptr_hit, rd_hit;
  assign start_w  = reg_wr && (reg_addr == ADDR_W'(OFS_START));
  assign accepted = seq_active && conv_done && !start_w;
  assign ptr_hit  = {{(NUM_RES-1){1'b0}}, 1'b1} << conv_ptr;
  assign rd_hit   = {{(NUM_RES-1){1'b0}}, 1'b1} << reg_addr[PTR_W-1:0];

  a_r3_short_range: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_active && !seq_len8 && $stable(seq_len8)) |-> (conv_ptr < PTR_W'(NUM_RES/2)));

  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> (cc_flags == '0 && conv_ptr == '0 && !seq_flag && seq_active));

  a_r10_set_on_conv: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> ((cc_flags & $past(ptr_hit)) == $past(ptr_hit)));

  a_r8_fast_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_clr && reg_rd && reg_addr[ADDR_W-1] && !accepted) |=> ((cc_flags & $past(rd_hit)) == '0));

  a_r11_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (!special_mode && reg_wr && reg_addr == ADDR_W'(OFS_STAT1) && !accepted) |=> $stable(cc_flags));

  a_r12_test_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !special_mode && (reg_addr == ADDR_W'(OFS_TSTH) || reg_addr == ADDR_W'(OFS_TSTL)))
      |-> (reg_rdata == '0));

  a_r5_seq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_flag) |-> ($past(accepted) ||
      $past(reg_wr && special_mode && reg_addr == ADDR_W'(OFS_STAT0))));
endmodule

bind adc_seq_status adc_seq_status_chk #(
  .NUM_RES(NUM_RES), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W)
) u_chk (.*);

// File: tb/adc_seq_status_bench.sv
module adc_seq_status_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        conv_done = 1'b0, scan_cont = 1'b0, seq_len8 = 1'b0;
  logic        fast_clr = 1'b0, special_mode = 1'b0;
  logic [2:0]  conv_ptr;
  logic        seq_active, seq_flag;
  logic [7:0]  cc_flags;
  logic [15:0] test_word;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  adc_seq_status u_adc_seq_status (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .conv_done(conv_done), .scan_cont(scan_cont), .seq_len8(seq_len8),
    .fast_clr(fast_clr), .special_mode(special_mode), .conv_ptr(conv_ptr),
    .seq_active(seq_active), .seq_flag(seq_flag), .cc_flags(cc_flags),
    .test_word(test_word)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic pulse_conv();
    @(negedge clk); conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ptr", conv_ptr, 0);
    chk("R1 flags", cc_flags, 0);
    chk("R1 seq", seq_flag, 0);
    chk("R1 active", seq_active, 0);
    chk("R1 test", test_word, 0);
    rst_n = 1'b1;

    // Sweep over length and scan mode: R2 R3 R4 R5 R6 R7
    for (int cfg = 0; cfg < 4; cfg++) begin
      int len;
      seq_len8 = cfg[0];
      scan_cont = cfg[1];
      fast_clr = 1'b0;
      len = seq_len8 ? 8 : 4;
      do_wr(4'h0, 8'h00);
      chk("R7 start ptr", conv_ptr, 0);
      chk("R7 start flags", cc_flags, 0);
      chk("R7 start seq", seq_flag, 0);
      chk("R7 start active", seq_active, 1);
      for (int k = 1; k <= len + 3; k++) begin
        int ep, ef, es, ea;
        pulse_conv();
        ep = scan_cont ? (k % len) : ((k < len) ? k : 0);
        ef = (k >= len) ? ((1 << len) - 1) : ((1 << k) - 1);
        es = (k >= len) ? 1 : 0;
        ea = (scan_cont || k < len) ? 1 : 0;
        chk("R3 ptr", conv_ptr, ep);
        chk("R6 flags", cc_flags, ef);
        chk("R5 seq", seq_flag, es);
        chk("R4 active", seq_active, ea);
        do_rd(4'h2, rd);
        chk("R2 stat0 byte", rd, (es << 7) | ep);
      end
    end

    // Continuous, fast: R5 only first pass, R8 fast clear
    seq_len8 = 1'b0; scan_cont = 1'b1; fast_clr = 1'b1;
    do_wr(4'h0, 8'h00);
    repeat (4) pulse_conv();
    chk("R5 first pass", seq_flag, 1);
    do_rd(4'h8, rd);
    chk("R8 slot0 clears seq", seq_flag, 0);
    chk("R8 slot0 flag", cc_flags, 8'h0E);
    repeat (4) pulse_conv();
    chk("R5 second pass no set", seq_flag, 0);
    chk("R6 refill", cc_flags, 8'h0F);
    do_rd(4'hA, rd);
    chk("R8 slot2 clear", cc_flags, 8'h0B);

    // Normal policy: R9
    fast_clr = 1'b0;
    do_rd(4'h9, rd);
    chk("R9 unarmed keep", cc_flags, 8'h0B);
    do_rd(4'h3, rd);
    chk("R2 stat1 byte", rd, 8'h0B);
    do_rd(4'h9, rd);
    chk("R9 armed clear", cc_flags, 8'h09);
    do_wr(4'h0, 8'h00);
    do_rd(4'h3, rd);
    pulse_conv();
    do_rd(4'h8, rd);
    chk("R9 set after status read", cc_flags, 8'h01);
    do_rd(4'h3, rd);
    do_rd(4'h8, rd);
    chk("R9 rearmed clear", cc_flags, 8'h00);

    // R10 set and clear in the same cycle
    fast_clr = 1'b1;
    chk("R10 ptr before", conv_ptr, 1);
    @(negedge clk); conv_done = 1'b1; reg_addr = 4'h9; reg_rd = 1'b1;
    @(negedge clk); conv_done = 1'b0; reg_rd = 1'b0;
    chk("R10 set wins", cc_flags[1], 1);

    // R7 start clears seq flag under normal policy
    fast_clr = 1'b0; scan_cont = 1'b0;
    do_wr(4'h0, 8'h00);
    repeat (4) pulse_conv();
    do_rd(4'h8, rd);
    chk("R8 normal no seq clear", seq_flag, 1);
    pulse_conv();
    chk("R4 idle ignore", cc_flags, 8'h0F);
    do_wr(4'h0, 8'h00);
    chk("R7 seq cleared", seq_flag, 0);

    // R11 R12 mode gating
    do_wr(4'h3, 8'h5A);
    chk("R11 normal write ignored", cc_flags, 0);
    do_wr(4'h2, 8'h80);
    chk("R11 normal seq write ignored", seq_flag, 0);
    do_wr(4'h4, 8'h77);
    chk("R12 normal write ignored", test_word, 0);
    special_mode = 1'b1;
    do_wr(4'h4, 8'h3C);
    do_wr(4'h5, 8'hC3);
    chk("R12 word", test_word, 16'h3CC3);
    do_rd(4'h4, rd);
    chk("R12 read hi", rd, 8'h3C);
    do_rd(4'h5, rd);
    chk("R12 read lo", rd, 8'hC3);
    do_wr(4'h3, 8'hA5);
    chk("R11 special flags", cc_flags, 8'hA5);
    do_wr(4'h2, 8'h80);
    chk("R11 special seq set", seq_flag, 1);
    do_wr(4'h2, 8'h00);
    chk("R11 special seq clear", seq_flag, 0);
    special_mode = 1'b0;
    do_rd(4'h4, rd);
    chk("R12 normal read zero", rd, 0);
    do_rd(4'h7, rd);
    chk("R2 unmapped zero", rd, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule